// File: doc/BRIEF.md
# Masked Logic-Operation Write Unit

This block sits in the write path of a random-access memory port. On each write it forms the word that goes back into the array. It combines the external data word with the word already stored at the target location, using a 4-bit raster-operation code. It also produces a per-bit write enable, so that bits which are masked keep their stored value.

A configuration strobe stands for the set/reset cycle. On that strobe the unit captures a new operation code, taken from the low address bits, together with a persistent mask. The code and mask then apply to every later write until the next strobe. A write may also carry a one-shot mask. That mask takes priority over the persistent one and makes the operation a plain copy of the data for that write only.

One code value does not select a write function. Instead it raises a sticky flag that switches the serial side of the memory to a one-bit-wide organization.

Top module: `lop_write_unit`

## Requirements
- R1: After reset the operation is through (write data equals data in), the persistent mask is all ones and `ser_x1` is 0.
- R2: For each bit the written value is `code[{~mem, ~din}]`. Codes with a fixed meaning:
  - 0000 writes zero and 1111 writes one.
  - 0101 is through.
  - 0110 is XOR and 1001 is XNOR.
  - 1010 is NOT din and 1100 is NOT mem.
  - 1000 is NOR and 1110 is NAND.
  - 0001 is din AND mem.
  - 0111 is din OR mem.
- R3: A clock edge with `cfg_load` high captures `cfg_code` and `cfg_mask`. Both hold unchanged until the next such edge.
- R4: Loading code 0011 leaves the active write function unchanged. The persistent mask is still captured.
- R5: While `cyc_mask_vld` is high, `cyc_mask` replaces the persistent mask and the operation is through, for that write only. The stored code and mask are not altered.
- R6: `wbe` equals the selected mask while `wr_valid` is high and is all zeros while `wr_valid` is low.
- R7: In every bit where `wbe` is 0, `wdata` carries the `mem` bit.
- R8: `ser_x1` is set by loading code 0011 and stays 1 through later loads until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Set/reset cycle strobe |
| cfg_code | input | 4 | Operation code to capture |
| cfg_mask | input | W | Persistent mask to capture (1 = bit written) |
| wr_valid | input | 1 | A write is in progress |
| cyc_mask_vld | input | 1 | One-shot mask present for this write |
| cyc_mask | input | W | One-shot mask (1 = bit written) |
| din | input | W | External data word |
| mem | input | W | Current stored word |
| wdata | output | W | Word to write back |
| wbe | output | W | Per-bit write enable |
| ser_x1 | output | 1 | Serial side switched to one-bit organization |

## Verification
The bench builds the unit with the default width of 4. At that width, data 1100 against memory 1010 presents all four (din, mem) bit pairs in one word, so a single write checks a whole code column. Walking all sixteen codes this way covers the full table. The same walk passes through the organization code, which shows that the previous function survives it and that the flag sticks. Directed writes then exercise one-shot override against different persistent masks, idle enables and reset in the middle of a run.

// File: rtl/lop_pkg.sv
package lop_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] ROP_THROUGH = 4'b0101;
  localparam logic [CODE_W-1:0] ROP_ORG_X1  = 4'b0011;

  // Truth-table lookup: the code itself is the table, indexed by inverted inputs.
  function automatic logic rop_bit(input logic [CODE_W-1:0] code,
                                   input logic d, input logic m);
    logic [1:0] idx;
    idx = {~m, ~d};
    return code[idx];
  endfunction
endpackage

// File: rtl/lop_cfg_regs.sv
module lop_cfg_regs
  import lop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [W-1:0]      cfg_mask,
  output logic [CODE_W-1:0] code_q,
  output logic [W-1:0]      mask_q,
  output logic              x1_q
);
  logic org_sel;
  assign org_sel = cfg_load && (cfg_code == ROP_ORG_X1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= ROP_THROUGH;
      mask_q <= '1;
      x1_q   <= 1'b0;
    end else if (cfg_load) begin
      mask_q <= cfg_mask;
      if (org_sel) x1_q <= 1'b1;
      else         code_q <= cfg_code;
    end
  end

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(mask_q));
  p_code_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    org_sel |=> $stable(code_q));
  p_x1_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    x1_q |=> x1_q);
endmodule

// File: rtl/lop_mask_sel.sv
module lop_mask_sel
  import lop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [CODE_W-1:0] code_q,
  input  logic [W-1:0]      mask_q,
  input  logic              cyc_vld,
  input  logic [W-1:0]      cyc_mask,
  input  logic              wr_valid,
  output logic [CODE_W-1:0] code_eff,
  output logic [W-1:0]      wbe
);
  always_comb begin
    code_eff = cyc_vld ? ROP_THROUGH : code_q;
    wbe      = wr_valid ? (cyc_vld ? cyc_mask : mask_q) : '0;
  end

  always_comb begin
    if (!wr_valid) p_idle_no_wbe_r6: assert (wbe == '0);
  end
endmodule

// File: rtl/lop_alu.sv
module lop_alu
  import lop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [CODE_W-1:0] code_eff,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      mem,
  input  logic [W-1:0]      wbe,
  output logic [W-1:0]      wdata
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic res;
    assign res      = rop_bit(code_eff, din[i], mem[i]);
    assign wdata[i] = wbe[i] ? res : mem[i];
  end
endmodule

// File: rtl/lop_write_unit.sv
module lop_write_unit
  import lop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [W-1:0]      cfg_mask,
  input  logic              wr_valid,
  input  logic              cyc_mask_vld,
  input  logic [W-1:0]      cyc_mask,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      mem,
  output logic [W-1:0]      wdata,
  output logic [W-1:0]      wbe,
  output logic              ser_x1
);
  logic [CODE_W-1:0] code_q;
  logic [W-1:0]      mask_q;
  logic [CODE_W-1:0] code_eff;

  lop_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
    .cfg_mask(cfg_mask), .code_q(code_q), .mask_q(mask_q), .x1_q(ser_x1)
  );

  lop_mask_sel #(.W(W)) u_sel (
    .code_q(code_q), .mask_q(mask_q), .cyc_vld(cyc_mask_vld),
    .cyc_mask(cyc_mask), .wr_valid(wr_valid), .code_eff(code_eff), .wbe(wbe)
  );

  lop_alu #(.W(W)) u_alu (
    .code_eff(code_eff), .din(din), .mem(mem), .wbe(wbe), .wdata(wdata)
  );

  p_masked_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~wbe & (wdata ^ mem)) == '0));
  p_override_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cyc_mask_vld) |-> (wdata == ((din & cyc_mask) | (mem & ~cyc_mask))));
endmodule

// File: tb/lop_write_unit_bench.sv
module lop_write_unit_bench;
  localparam int W = 4;
  // vector: code[20:17] mask[16:13] cyc_vld[12] cyc_mask[11:8] din[7:4] mem[3:0]
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {4'h0,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'h1,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'h2,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'h3,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'h4,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'h5,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'h6,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'h7,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'h8,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'h9,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'hA,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'hB,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'hC,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'hD,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'hE,4'hF,1'b0,4'h0,4'hC,4'hA}, {4'hF,4'hF,1'b0,4'h0,4'hC,4'hA},
    {4'h6,4'hA,1'b0,4'h0,4'h5,4'h3}, {4'h1,4'h6,1'b1,4'h9,4'h5,4'h3},
    {4'hF,4'h0,1'b0,4'h0,4'h0,4'hA}, {4'h3,4'h5,1'b0,4'h0,4'hF,4'h0}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_load = 0, wr_valid = 0, cyc_mask_vld = 0;
  logic [3:0] cfg_code = 0;
  logic [W-1:0] cfg_mask = 0, cyc_mask = 0, din = 0, mem = 0;
  logic [W-1:0] wdata, wbe;
  logic ser_x1;
  int n_run = 0, n_fail = 0;
  logic [3:0] m_code;
  logic [W-1:0] m_mask;

  always #4 clk = ~clk;

  lop_write_unit #(.W(W)) u_lop_write_unit (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_code(cfg_code),
    .cfg_mask(cfg_mask), .wr_valid(wr_valid), .cyc_mask_vld(cyc_mask_vld),
    .cyc_mask(cyc_mask), .din(din), .mem(mem), .wdata(wdata), .wbe(wbe),
    .ser_x1(ser_x1)
  );

  function automatic logic op_ref(input logic [3:0] c, input logic d, input logic m);
    case (c)
      4'h0: return 1'b0;      4'h1: return d & m;
      4'h2: return ~d & m;    4'h3: return 1'bx;
      4'h4: return d & ~m;    4'h5: return d;
      4'h6: return d ^ m;     4'h7: return d | m;
      4'h8: return ~(d | m);  4'h9: return ~(d ^ m);
      4'hA: return ~d;        4'hB: return ~d | m;
      4'hC: return ~m;        4'hD: return d | ~m;
      4'hE: return ~(d & m);  default: return 1'b1;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [3:0] c, input logic [W-1:0] mk);
    @(negedge clk);
    cfg_load = 1; cfg_code = c; cfg_mask = mk;
    @(negedge clk);
    cfg_load = 0;
    m_mask = mk;
    if (c != 4'h3) m_code = c;
  endtask

  task automatic do_write(input logic cv, input logic [W-1:0] cm,
                          input logic [W-1:0] d, input logic [W-1:0] m, input string tag);
    logic [W-1:0] ew, ee;
    wr_valid = 1; cyc_mask_vld = cv; cyc_mask = cm; din = d; mem = m;
    #1;
    ee = cv ? cm : m_mask;
    for (int i = 0; i < W; i++)
      ew[i] = ee[i] ? (cv ? d[i] : op_ref(m_code, d[i], m[i])) : m[i];
    check(wdata === ew, {tag, " wdata"}, 8'(wdata), 8'(ew));
    check(wbe === ee, {tag, " wbe"}, 8'(wbe), 8'(ee));
    @(negedge clk);
    wr_valid = 0; cyc_mask_vld = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_code = 4'h5; m_mask = '1;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(ser_x1 === 1'b0, "R1 ser_x1", 8'(ser_x1), 8'h0);
    do_write(0, 0, 4'h9, 4'h6, "R1 through");
    // R2 R3 R4 R5 R7 table walk
    for (int v = 0; v < NV; v++) begin
      load_cfg(VEC[v][20:17], VEC[v][16:13]);
      do_write(VEC[v][12], VEC[v][11:8], VEC[v][7:4], VEC[v][3:0], "R2/R4/R5/R7 vec");
    end
    // R3 persistence over several writes
    load_cfg(4'h6, 4'h7);
    do_write(0, 0, 4'hF, 4'h3, "R3 hold1");
    do_write(0, 0, 4'h1, 4'h8, "R3 hold2");
    // R5 one-shot then back to stored values
    do_write(1, 4'h2, 4'hA, 4'h5, "R5 override");
    do_write(0, 0, 4'hA, 4'h5, "R5 after");
    // R6 idle: no enables
    wr_valid = 0; din = 4'hF; mem = 4'h0; #1;
    check(wbe === 4'h0, "R6 idle wbe", 8'(wbe), 8'h0);
    @(negedge clk);
    // R8 sticky flag through later loads
    check(ser_x1 === 1'b1, "R8 set", 8'(ser_x1), 8'h1);
    load_cfg(4'h5, 4'hF);
    check(ser_x1 === 1'b1, "R8 sticky", 8'(ser_x1), 8'h1);
    // R1 reset mid-run
    load_cfg(4'h0, 4'h3);
    rst_n = 0; #1;
    m_code = 4'h5; m_mask = '1;
    check(ser_x1 === 1'b0, "R1 reset flag", 8'(ser_x1), 8'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    do_write(0, 0, 4'h6, 4'h9, "R1 after reset");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule